// File: doc/BRIEF.md
# Programmable Clock Enable Divider

This block takes one input clock and produces three clock-enable pulse streams for a core domain, a bus domain and a peripheral domain. Each stream is a single-cycle, registered enable. It is not a gated or generated clock. Logic downstream keeps running on the input clock and advances only in cycles where its enable is high.

The ratios are set by a 16-bit control word that is loaded through a simple write strobe. The word can always be read back as written. Three 3-bit fields of the word each pick a divisor from a fixed lookup table. The tables contain non-power-of-two ratios, and their reserved codes saturate to divide-by-8.

Each enable is produced by its own down-counter. The counter takes a new divisor only when it reaches its terminal count. A rewrite therefore lets the period in progress finish at the old ratio, and no short or stretched pulse gap appears.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the readback is 0x0000. While reset is high all three enables are low.
- R2: A write strobe stores all 16 bits of the write data, and the readback shows that value from the next cycle on. This includes reserved codes and unused bits. Without a strobe the stored value does not change.
- R3: Bits [8:6] select the core ratio. Codes 0..7 map to divisors 1, 2, 3, 4, 5, 8, 8, 8.
- R4: Bits [5:3] select the bus ratio, using the same mapping as R3.
- R5: Bits [2:0] select the peripheral ratio. Codes 0..7 map to divisors 2, 3, 4, 6, 8, 8, 8, 8.
- R6: When a divisor of 1 is in effect, its enable stays high on every cycle.
- R7: When a divisor N is in effect, its enable is high for exactly one cycle in every N. The first pulse comes on the first clock edge after reset is released.
- R8: A new divisor takes effect only at a terminal count. The gap running when the write occurs completes at the old divisor, and the following gap uses the new one.
- R9: After reset, the core and bus enables run at the full input rate and the peripheral enable pulses every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| ctrl_rd | output | 16 | Control word readback |
| core_en | output | 1 | Core-domain clock enable |
| bus_en | output | 1 | Bus-domain clock enable |
| per_en | output | 1 | Peripheral-domain clock enable |

## Verification
The assertions check several properties on every cycle:
- each counter stays below its latched divisor;
- a pulse appears exactly after a terminal count;
- the latched divisor changes only at terminal count;
- a divisor of 1 gives a continuous enable;
- the control word tracks the strobe.

Other behaviour can only be shown by the bench scenarios. These cover the table mappings for every code class, the exact pulse spacing after reset, and the old-then-new gap that follows a mid-period rewrite. The bench compares these against an independent cycle model.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int CTRL_W  = 16;
  localparam int CODE_W  = 3;
  localparam int MAX_DIV = 8;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam int CNT_W   = $clog2(MAX_DIV);

  typedef enum logic {TBL_CORE = 1'b0, TBL_PERIPH = 1'b1} tbl_kind_e;

  function automatic logic [DIV_W-1:0] core_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd0: core_ratio = DIV_W'(1);
      3'd1: core_ratio = DIV_W'(2);
      3'd2: core_ratio = DIV_W'(3);
      3'd3: core_ratio = DIV_W'(4);
      3'd4: core_ratio = DIV_W'(5);
      default: core_ratio = DIV_W'(MAX_DIV);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] periph_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd0: periph_ratio = DIV_W'(2);
      3'd1: periph_ratio = DIV_W'(3);
      3'd2: periph_ratio = DIV_W'(4);
      3'd3: periph_ratio = DIV_W'(6);
      default: periph_ratio = DIV_W'(MAX_DIV);
    endcase
  endfunction
endpackage

// File: rtl/ctrl_word_reg.sv
module ctrl_word_reg #(
  parameter int W = clk_ratio_pkg::CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end

  // R2: a strobe loads the data, no strobe holds the word
  p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (word_q == $past(wr_data)));
  p_word_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(word_q));
endmodule

// File: rtl/ratio_decode.sv
module ratio_decode
  import clk_ratio_pkg::*;
#(
  parameter tbl_kind_e KIND = TBL_CORE
) (
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  ratio
);
  generate
    if (KIND == TBL_PERIPH) begin : g_periph
      always_comb ratio = periph_ratio(code);
    end else begin : g_core
      always_comb ratio = core_ratio(code);
    end
  endgenerate
endmodule

// File: rtl/en_divider.sv
module en_divider
  import clk_ratio_pkg::*;
#(
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_req,
  output logic             en_q
);
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div_act;
  logic             term;

  assign term = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      div_act <= DIV_W'(RST_DIV);
      en_q    <= 1'b0;
    end else begin
      en_q <= term;
      if (term) begin
        div_act <= div_req;
        cnt     <= CNT_W'(div_req - DIV_W'(1));
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  p_div_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    div_req != '0);
  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    DIV_W'(cnt) < div_act);
  p_pulse_at_term_r7: assert property (@(posedge clk) disable iff (rst)
    term |=> en_q);
  p_quiet_mid_r7: assert property (@(posedge clk) disable iff (rst)
    !term |=> !en_q);
  p_latch_at_term_r8: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(div_act));
  p_div1_high_r6: assert property (@(posedge clk) disable iff (rst)
    (div_act == DIV_W'(1) && div_req == DIV_W'(1)) |=> en_q);
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int CORE_LSB = 6,
  parameter int BUS_LSB  = 3,
  parameter int PER_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              core_en,
  output logic              bus_en,
  output logic              per_en
);
  localparam int NUM_OUT = 3;
  localparam int FIELD_LSB [NUM_OUT] = '{CORE_LSB, BUS_LSB, PER_LSB};

  logic [CTRL_W-1:0] word_q;
  logic [DIV_W-1:0]  ratio [NUM_OUT];
  logic [NUM_OUT-1:0] en_vec;

  ctrl_word_reg #(.W(CTRL_W)) u_word (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .word_q(word_q)
  );

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      localparam tbl_kind_e KIND = (i == NUM_OUT - 1) ? TBL_PERIPH : TBL_CORE;
      localparam int        RDIV = (i == NUM_OUT - 1) ? 2 : 1;

      ratio_decode #(.KIND(KIND)) u_dec (
        .code (word_q[FIELD_LSB[i] +: CODE_W]),
        .ratio(ratio[i])
      );

      en_divider #(.RST_DIV(RDIV)) u_div (
        .clk(clk), .rst(rst), .div_req(ratio[i]), .en_q(en_vec[i])
      );
    end
  endgenerate

  assign ctrl_rd = word_q;
  assign core_en = en_vec[0];
  assign bus_en  = en_vec[1];
  assign per_en  = en_vec[2];

  // R1: enables stay quiet while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    rst |=> (en_vec == '0 && ctrl_rd == '0));
endmodule

// File: tb/clk_ratio_ctrl_test.sv
module clk_ratio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] ctrl_rd;
  logic        core_en, bus_en, per_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_ratio_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
  );

  // Reference model: ratio tables from the requirements, behavioural countdown
  int core_tbl [8] = '{1, 2, 3, 4, 5, 8, 8, 8};
  int per_tbl  [8] = '{2, 3, 4, 6, 8, 8, 8, 8};
  int m_word = 0;
  int m_left [3] = '{0, 0, 0};
  bit m_en [3] = '{0, 0, 0};

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_word = 0;
      for (int k = 0; k < 3; k++) begin m_left[k] = 0; m_en[k] = 0; end
    end else begin
      for (int k = 0; k < 3; k++) begin
        int d;
        d = (k == 0) ? core_tbl[(m_word >> 6) & 7] :
            (k == 1) ? core_tbl[(m_word >> 3) & 7] : per_tbl[m_word & 7];
        if (m_left[k] == 0) begin m_en[k] = 1; m_left[k] = d - 1; end
        else begin m_en[k] = 0; m_left[k] = m_left[k] - 1; end
      end
      if (wr_en) m_word = wr_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare on every falling edge once enabled
  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    check(core_en == m_en[0], "R3 core enable", core_en, m_en[0]);
    check(bus_en  == m_en[1], "R4 bus enable",  bus_en,  m_en[1]);
    check(per_en  == m_en[2], "R5 periph enable", per_en, m_en[2]);
    check(ctrl_rd == 16'(m_word), "R2 readback", ctrl_rd, m_word);
  end

  task automatic write_word(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check(ctrl_rd == 16'h0, "R1 reset readback", ctrl_rd, 0);
    check({core_en, bus_en, per_en} == 3'b000, "R1 enables low in reset",
          {core_en, bus_en, per_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ctrl_rd == 16'h0, "R1 readback after reset", ctrl_rd, 0);
    cmp_on = 1;
    // R9: default rates over 8 cycles
    begin
      int c_cnt = 0, b_cnt = 0, p_cnt = 0;
      for (int i = 0; i < 8; i++) begin
        c_cnt += core_en; b_cnt += bus_en; p_cnt += per_en;
        @(negedge clk);
      end
      check(c_cnt == 8, "R9 core full rate", c_cnt, 8);
      check(b_cnt == 8, "R9 bus full rate", b_cnt, 8);
      check(p_cnt == 4, "R9 periph half rate", p_cnt, 4);
    end
    // R6: divide-by-1 core stays high while other fields change
    write_word(16'h0001);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(core_en == 1'b1, "R6 core continuous", core_en, 1);
    end
    // Non-power-of-two ratios: core 3, bus 5, periph 6
    write_word(16'h00A3);
    repeat (40) @(negedge clk);
    // R7: measure core spacing of 3
    while (!core_en) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!core_en);
    check(n == 3, "R7 core gap", n, 3);
    // Reserved codes saturate to 8, unused bits stored
    write_word(16'hFFFF);
    repeat (30) @(negedge clk);
    check(ctrl_rd == 16'hFFFF, "R2 full word readback", ctrl_rd, 16'hFFFF);
    write_word(16'h0175);  // core code5, bus code6, periph code5
    repeat (40) @(negedge clk);
    // R8: periph at 8, rewrite to 2 just after a pulse
    write_word(16'h0004);
    repeat (12) @(negedge clk);
    while (!per_en) @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h0000;
    n = 0;
    do begin @(negedge clk); wr_en = 1'b0; n++; end while (!per_en);
    check(n == 8, "R8 old gap completes", n, 8);
    n = 0;
    do begin @(negedge clk); n++; end while (!per_en);
    check(n == 2, "R8 new gap applied", n, 2);
    // Sweep every code on each field
    for (int c = 0; c < 8; c++) begin
      write_word(16'((c << 6) | (((c + 3) & 7) << 3) | ((c + 5) & 7)));
      repeat (24) @(negedge clk);
    end
    // reset mid-run returns to defaults
    rst = 1'b1; cmp_on = 0;
    @(negedge clk);
    check(ctrl_rd == 16'h0, "R1 readback cleared", ctrl_rd, 0);
    check({core_en, bus_en, per_en} == 3'b000, "R1 enables cleared",
          {core_en, bus_en, per_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1;
    repeat (10) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule